// File: doc/BRIEF.md
# Signed Multiply High-Word Accumulate Unit

This datapath multiplies two signed operands into a double-width product, may merge an accumulator into the upper half of that product, may round, and returns the upper word. The merge has two forms. In the add form the shifted accumulator is added to the product. In the subtract form the product is taken away from the shifted accumulator. The merge works on the full double-width value, so carries and borrows from the lower half reach the returned word. Rounding is applied after the merge and before the upper word is taken.

The controls come from one of two places. Direct flags can drive them, or a small decoder can derive them from an instruction word in either of two bit layouts. One set of operands is accepted on every cycle that the input strobe is high. The result appears in an output register one cycle later and holds its value until the next accepted input.

Top module: `hiword_mac`

## Requirements
- R1: The product is the full 64-bit two's-complement product of `op_a` and `op_b`, both treated as signed. With accumulation and rounding off, `res` is product bits 63:32.
- R2: With add accumulation, the intermediate is the product plus `{acc_in, 32'h0}`, and `acc_in` is zero-extended. `res` is intermediate bits 63:32.
- R3: With subtract accumulation, the intermediate is `{acc_in, 32'h0}` minus the product. The order is not product minus accumulator.
- R4: With rounding on, 0x80000000 is added to the intermediate after the accumulate or subtract step and before bits 63:32 are taken.
- R5: All 64-bit arithmetic wraps modulo 2^64. There is no saturation.
- R6: When `use_dec`=0, `dir_acc` enables accumulation, `dir_sub` selects subtract (1) or add (0), and `dir_rnd` enables rounding. `insn` and `enc_b` have no effect.
- R7: When `use_dec`=1 and `enc_b`=0 (layout A), `insn[6]`=1 selects subtract and `insn[6]`=0 selects add. `insn[5]` enables rounding.
- R8: When `use_dec`=1 and `enc_b`=1 (layout B), `insn[20]`=1 selects add and `insn[20]`=0 selects subtract. `insn[4]` enables rounding.
- R9: When `use_dec`=1, the accumulator field `insn[15:12]` equal to 15 disables accumulation, and `acc_in` is then ignored. Any other field value enables accumulation. This holds in both layouts.
- R10: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. `res` changes only in response to an accepted input and otherwise holds its value.
- R11: A synchronous active-high `rst` clears `res_valid` and `res` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept operands this cycle |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| acc_in | input | 32 | Accumulator word merged into the upper half |
| use_dec | input | 1 | 1: controls from instruction decode, 0: direct flags |
| enc_b | input | 1 | Instruction layout select (0 = A, 1 = B) |
| insn | input | 32 | Instruction word for the decoder |
| dir_acc | input | 1 | Direct flag: enable accumulation |
| dir_sub | input | 1 | Direct flag: subtract form |
| dir_rnd | input | 1 | Direct flag: round |
| res_valid | output | 1 | Result register holds a new result |
| res | output | 32 | Upper word of the final 64-bit value |

## Verification
The bench aims at operands whose low product half carries into or borrows from the upper word. These cases catch a design that merges the accumulator only into the 32-bit high word: such a design is off by one wherever the lower half matters. A subtract case with a small product checks the operand order, since a reversed order returns a near-zero word instead of all ones. A rounding case checks that rounding comes after the merge, because rounding first and then subtracting gives all ones where the correct order gives zero. Decoder cases use the polarity of each layout's add/subtract bit and the all-ones accumulator field with a nonzero `acc_in`, so an inverted polarity or a leaked accumulator shows up in `res`.

// File: rtl/hiword_pkg.sv
package hiword_pkg;
  // Control bundle shared by the decoder and the datapath.
  typedef struct packed {
    logic acc_en;
    logic sub;
    logic rnd;
  } hw_ctl_t;

  // Instruction field positions.
  localparam int LA_SUB_BIT = 6;
  localparam int LA_RND_BIT = 5;
  localparam int LB_ADD_BIT = 20;
  localparam int LB_RND_BIT = 4;
  localparam int FLD_LO     = 12;
  localparam int FLD_W      = 4;
endpackage

// File: rtl/hiword_decode.sv
module hiword_decode
  import hiword_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic          use_dec,
  input  logic          enc_b,
  input  logic [IW-1:0] insn,
  input  logic          dir_acc,
  input  logic          dir_sub,
  input  logic          dir_rnd,
  output hw_ctl_t       ctl
);
  localparam logic [FLD_W-1:0] NO_ACC = '1;

  logic [FLD_W-1:0] fld;
  assign fld = insn[FLD_LO +: FLD_W];

  always_comb begin
    if (!use_dec) begin
      ctl.acc_en = dir_acc;
      ctl.sub    = dir_sub;
      ctl.rnd    = dir_rnd;
    end else begin
      ctl.acc_en = (fld != NO_ACC);
      if (enc_b) begin
        ctl.sub = ~insn[LB_ADD_BIT];
        ctl.rnd = insn[LB_RND_BIT];
      end else begin
        ctl.sub = insn[LA_SUB_BIT];
        ctl.rnd = insn[LA_RND_BIT];
      end
    end
  end

  // R9: an all-ones field in decode mode never enables accumulation
  always_comb begin
    if (!$isunknown({use_dec, fld, ctl.acc_en}) && use_dec && fld == NO_ACC)
      a_r9_field_off: assert (!ctl.acc_en);
  end
endmodule

// File: rtl/hiword_datapath.sv
module hiword_datapath
  import hiword_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] acc,
  input  hw_ctl_t      ctl,
  output logic [W-1:0] hi
);
  localparam int P = 2 * W;
  localparam logic [P-1:0] RND_K = P'(1) << (W - 1);

  logic signed [P-1:0] a_x, b_x, prod;
  logic [P-1:0] acc_sh, merged, fin;

  assign a_x    = {{W{a[W-1]}}, a};
  assign b_x    = {{W{b[W-1]}}, b};
  assign prod   = a_x * b_x;
  assign acc_sh = {acc, {W{1'b0}}};

  always_comb begin
    if (!ctl.acc_en)  merged = prod;
    else if (ctl.sub) merged = acc_sh - prod;
    else              merged = acc_sh + prod;
  end

  assign fin = merged + (ctl.rnd ? RND_K : '0);
  assign hi  = fin[P-1:W];

  // R4: rounding moves the upper word by at most one (mod 2^W)
  logic [W-1:0] rnd_step;
  assign rnd_step = hi - merged[P-1:W];
  always_comb begin
    if (!$isunknown(rnd_step))
      a_r4_round_step: assert (rnd_step == '0 || rnd_step == W'(1));
  end

  // R1: a zero operand with no accumulation gives a zero upper word
  always_comb begin
    if (!$isunknown({a, b, ctl, hi}) && !ctl.acc_en && (a == '0 || b == '0))
      a_r1_zero_operand: assert (hi == '0);
  end
endmodule

// File: rtl/hiword_mac.sv
module hiword_mac
  import hiword_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  acc_in,
  input  logic          use_dec,
  input  logic          enc_b,
  input  logic [IW-1:0] insn,
  input  logic          dir_acc,
  input  logic          dir_sub,
  input  logic          dir_rnd,
  output logic          res_valid,
  output logic [W-1:0]  res
);
  hw_ctl_t      ctl;
  logic [W-1:0] hi_d;

  hiword_decode #(.IW(IW)) u_dec (
    .use_dec (use_dec),
    .enc_b   (enc_b),
    .insn    (insn),
    .dir_acc (dir_acc),
    .dir_sub (dir_sub),
    .dir_rnd (dir_rnd),
    .ctl     (ctl)
  );

  hiword_datapath #(.W(W)) u_dp (
    .a   (op_a),
    .b   (op_b),
    .acc (acc_in),
    .ctl (ctl),
    .hi  (hi_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= hi_d;
    end
  end

  // R10: a result follows every accepted input
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R10: no result without an accepted input
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  // R10: result held while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res));
  // R11: reset leaves the output cleared
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!res_valid && res == '0));
endmodule

// File: tb/sim_hiword_mac.sv
module sim_hiword_mac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_in = '0, insn = '0;
  logic        use_dec = 1'b0, enc_b = 1'b0;
  logic        dir_acc = 1'b0, dir_sub = 1'b0, dir_rnd = 1'b0;
  logic        res_valid;
  logic [31:0] res;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  hiword_mac u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .use_dec(use_dec), .enc_b(enc_b), .insn(insn),
    .dir_acc(dir_acc), .dir_sub(dir_sub), .dir_rnd(dir_rnd),
    .res_valid(res_valid), .res(res)
  );

  function automatic logic [31:0] model(
    input logic [31:0] a, b, acc, ins,
    input logic ud, eb, fa, fs, fr);
    logic ae, sb, rd;
    logic signed [63:0] p;
    logic [63:0] m;
    if (ud) begin
      ae = (ins[15:12] != 4'hF);
      sb = eb ? !ins[20] : ins[6];
      rd = eb ? ins[4] : ins[5];
    end else begin
      ae = fa; sb = fs; rd = fr;
    end
    p = 64'($signed(a)) * 64'($signed(b));
    m = p;
    if (ae) m = sb ? ({acc, 32'h0} - m) : ({acc, 32'h0} + m);
    if (rd) m = m + 64'h8000_0000;
    return m[63:32];
  endfunction

  logic        ev = 1'b0;
  logic [31:0] er = '0;
  string       etag = "R11";
  bit          armed = 1'b0;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      ev <= 1'b0; er <= '0; etag <= "R11";
    end else begin
      ev <= in_valid;
      etag <= in_valid ? cur_tag : "R10";
      if (in_valid)
        er <= model(op_a, op_b, acc_in, insn, use_dec, enc_b, dir_acc, dir_sub, dir_rnd);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(res_valid == ev, etag, 32'(res_valid), 32'(ev));
      chk(res == er, etag, res, er);
    end
  end

  task automatic issue(input string tag, input logic [31:0] a, b, acc, ins,
                       input logic ud, eb, fa, fs, fr);
    @(negedge clk);
    cur_tag = tag;
    op_a = a; op_b = b; acc_in = acc; insn = ins;
    use_dec = ud; enc_b = eb; dir_acc = fa; dir_sub = fs; dir_rnd = fr;
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom; op_b = $urandom; acc_in = $urandom; insn = $urandom;
      use_dec = 1'($urandom); dir_acc = 1'($urandom);
    end
  endtask

  task automatic lit(input string tag, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(res_valid && res == exp, tag, res, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(res_valid == 1'b0 && res == '0, "R11", res, 32'h0);
    rst = 1'b0;
    idle(2);

    // R1 corner products
    issue("R1", 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    lit("R1", 32'h4000_0000);
    issue("R1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    lit("R1", 32'hFFFF_FFFF);
    // R4 rounding carries into the upper word
    issue("R4", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 0, 0, 0, 1);
    lit("R4", 32'h0000_0000);
    // R2 add with zero-extended accumulator
    issue("R2", 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h0, 0, 0, 1, 0, 0);
    lit("R2", 32'hFFFF_FFFF);
    // R5 wrap on add
    issue("R5", 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 0, 0, 1, 0, 0);
    lit("R5", 32'h3FFF_FFFF);
    // R3 subtract order, borrow from the lower half
    issue("R3", 32'h1, 32'h1, 32'h0, 32'h0, 0, 0, 1, 1, 0);
    lit("R3", 32'hFFFF_FFFF);
    // R4 rounding after subtract
    issue("R4", 32'h1, 32'h1, 32'h0, 32'h0, 0, 0, 1, 1, 1);
    lit("R4", 32'h0000_0000);
    // R6 direct mode ignores insn (insn would select plain multiply in decode)
    issue("R6", 32'h1, 32'h1, 32'h5, 32'h0000_F000, 0, 1, 1, 0, 0);
    lit("R6", 32'h0000_0005);
    // R7 layout A: bit6 subtract, bit5 round
    issue("R7", 32'h1, 32'h1, 32'h0, 32'h0000_0040, 1, 0, 0, 0, 0);
    lit("R7", 32'hFFFF_FFFF);
    issue("R7", 32'h1, 32'h1, 32'h0, 32'h0000_0060, 1, 0, 0, 0, 0);
    lit("R7", 32'h0000_0000);
    // R8 layout B: bit20 add, bit4 round
    issue("R8", 32'h1, 32'h1, 32'h3, 32'h0010_0000, 1, 1, 0, 0, 0);
    lit("R8", 32'h0000_0003);
    issue("R8", 32'h1, 32'h1, 32'h0, 32'h0000_0010, 1, 1, 0, 0, 0);
    lit("R8", 32'h0000_0000);
    // R9 all-ones field ignores acc_in
    issue("R9", 32'h2, 32'h3, 32'h1234_5678, 32'h0010_F000, 1, 1, 0, 0, 0);
    lit("R9", 32'h0000_0000);
    issue("R9", 32'h2, 32'h3, 32'h1234_5678, 32'h0000_F040, 1, 0, 0, 0, 0);
    lit("R9", 32'h0000_0000);

    // R10 hold while idle
    idle(5);

    // Random: six direct variants with corner operands mixed in
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < 200; i++) begin
        logic [31:0] ra, rb;
        ra = $urandom; rb = $urandom;
        case ($urandom_range(0, 7))
          0: ra = 32'h8000_0000;
          1: rb = 32'h7FFF_FFFF;
          2: ra = 32'hFFFF_FFFF;
          3: rb = 32'h0;
          default: ;
        endcase
        issue(v < 2 ? "R1" : (v < 4 ? "R2" : "R3"), ra, rb, $urandom, $urandom,
              0, 1'($urandom), v >= 2, v >= 4, 1'(v % 2));
        if ($urandom_range(0, 5) == 0) idle(1);
      end
    end
    // Random decode in both layouts
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ri;
      ri = $urandom;
      if ($urandom_range(0, 3) == 0) ri[15:12] = 4'hF;
      issue(i % 2 ? "R8" : "R7", $urandom, $urandom, $urandom, ri,
            1, 1'(i % 2), 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 5) == 0) idle(2);
    end
    idle(3);

    // R11 reset mid-stream
    issue("R11", 32'h7, 32'h9, 32'h0, 32'h0, 0, 0, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    #1;
    chk(res_valid == 1'b0 && res == '0, "R11", res, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule